// File: doc/BRIEF.md
# Radix-4 Booth Partial Product Generator

This combinational block recodes a signed multiplier operand X in overlapping three-bit windows and forms one partial-product row per window from a signed multiplicand Y. Each row holds zero, plus or minus one times Y, or plus or minus two times Y. Every row is placed at its column weight inside a product-wide field. Negative multiples are formed as a bitwise complement, and a separate vector of negate bits supplies the missing +1 at each row's base column. No row carries a full sign extension. The generator instead inverts the top bit of every row after the first, adds two extra columns to the first row, and places a constant one just above each later row.

The outputs feed a carry-save reduction tree directly. If every emitted bit is summed by its weight, modulo 2^(XW+YW), the result is the signed product X*Y. The tree and the final carry-propagate adder belong to the next stage.

Top module: `booth_pp_gen`

## Requirements
- R1: The sum of every bit of `rows_o` and `neg_o`, each weighted by its column, modulo 2^(XW+YW), equals the two's-complement product of the signed operands `x_i` and `y_i`.
- R2: There are ceil(XW/2) rows. Row k occupies bits [k*W +: W] of `rows_o` with W = XW+YW, has its base at column 2k, and has no set bit below column 2k.
- R3: Row k's recoding window is {xe[2k+2], xe[2k+1], xe[2k]}, where xe is X with a zero appended below bit 0. Its multiple is m = -2*xe[2k+2] + xe[2k+1] + xe[2k]. Bits j = 0..YW-1 at column 2k+j are zero for m = 0, bit j of m*Y for m > 0, and the complement of bit j of |m|*Y for m < 0.
- R4: `neg_o` bit 2k is 1 exactly when row k's multiple is negative; odd columns of `neg_o` are always 0.
- R5: For every row k > 0, the bit at column 2k+YW is the inverse of bit YW of the selected (possibly complemented) multiple, and column 2k+YW+1 holds a constant 1.
- R6: For row 0, column YW holds bit YW of the selected multiple, column YW+1 repeats it, and column YW+2 holds its inverse.
- R7: Any bit whose column would be XW+YW or higher is dropped. The constant one of the last row is omitted when XW is odd.
- R8: When XW is odd, the topmost window takes its upper bit from a copy of X's sign bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | XW | Signed multiplier operand, recoded in windows |
| y_i | input | YW | Signed multiplicand operand |
| rows_o | output | ceil(XW/2)*(XW+YW) | Partial-product rows, row k in slice [k*W +: W], bits at their column weight |
| neg_o | output | XW+YW | Negate correction bits, one per row at its base column |

## Verification
Two corrections can fall on the same column sum at once: a row's complemented multiple with its negate bit, and the inverted top bit with the constant one that replaces sign extension. Operands whose windows give -2 or -1 provoke both, and the most negative X or Y provokes them at the edges. In the odd-width case the top constant is truncated in the same evaluation. A behavioural model in the bench rebuilds each row from the multiple it computes and judges each field separately. It also checks the weighted sum against X*Y, exhaustively at 4x4 and 5x7 and at random plus corner points at 8x12.

// File: rtl/booth_pp_pkg.sv
package booth_pp_pkg;

  // Multiple selected by one recoding window
  typedef enum logic [2:0] {
    MUL_ZERO = 3'd0,
    MUL_POS1 = 3'd1,
    MUL_POS2 = 3'd2,
    MUL_NEG1 = 3'd3,
    MUL_NEG2 = 3'd4
  } mult_e;

  // Window bits {upper, middle, lower neighbour}
  function automatic mult_e decode_window(input logic [2:0] win);
    mult_e m;
    unique case (win)
      3'b001, 3'b010: m = MUL_POS1;
      3'b011:         m = MUL_POS2;
      3'b100:         m = MUL_NEG2;
      3'b101, 3'b110: m = MUL_NEG1;
      default:        m = MUL_ZERO;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/booth_pp_enc.sv
module booth_pp_enc
  import booth_pp_pkg::*;
(
  input  logic [2:0] win_i,
  output mult_e      mul_o,
  output logic       neg_o
);

  always_comb begin
    mul_o = decode_window(win_i);
    neg_o = (mul_o == MUL_NEG1) || (mul_o == MUL_NEG2);
  end

endmodule

// File: rtl/booth_pp_row.sv
module booth_pp_row
  import booth_pp_pkg::*;
#(
  parameter int YW    = 12,
  parameter bit FIRST = 1'b0
) (
  input  mult_e         mul_i,
  input  logic [YW-1:0] y_i,
  output logic [YW:0]   bits_o
);

  localparam int EW = YW + 2;

  logic [EW-1:0] y_ext;
  logic [YW:0]   sel;

  assign y_ext = {y_i[YW-1], y_i, 1'b0};

  always_comb begin
    for (int j = 0; j <= YW; j++) begin
      unique case (mul_i)
        MUL_POS1: sel[j] =  y_ext[j+1];
        MUL_POS2: sel[j] =  y_ext[j];
        MUL_NEG1: sel[j] = ~y_ext[j+1];
        MUL_NEG2: sel[j] = ~y_ext[j];
        default:  sel[j] = 1'b0;
      endcase
    end
  end

  generate
    if (FIRST) begin : g_first
      assign bits_o = sel;
    end else begin : g_later
      assign bits_o = {~sel[YW], sel[YW-1:0]};
    end
  endgenerate

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_pp_pkg::*;
#(
  parameter int XW = 8,
  parameter int YW = 12
) (
  input  logic [XW-1:0]                      x_i,
  input  logic [YW-1:0]                      y_i,
  output logic [((XW+1)/2)*(XW+YW)-1:0]      rows_o,
  output logic [XW+YW-1:0]                   neg_o
);

  localparam int W  = XW + YW;
  localparam int NR = (XW + 1) / 2;
  localparam int XE = 2 * NR + 1;

  logic [XE-1:0] x_ext;
  mult_e         mul   [NR];
  logic          negb  [NR];
  logic [YW:0]   rbits [NR];

  generate
    if (XW % 2 == 1) begin : g_odd
      assign x_ext = {x_i[XW-1], x_i, 1'b0};
    end else begin : g_even
      assign x_ext = {x_i, 1'b0};
    end

    for (genvar k = 0; k < NR; k++) begin : g_row
      booth_pp_enc u_enc (
        .win_i (x_ext[2*k+2:2*k]),
        .mul_o (mul[k]),
        .neg_o (negb[k])
      );
      booth_pp_row #(.YW(YW), .FIRST(k == 0)) u_row (
        .mul_i  (mul[k]),
        .y_i    (y_i),
        .bits_o (rbits[k])
      );
    end
  endgenerate

  always_comb begin
    neg_o = '0;
    for (int k = 0; k < NR; k++) neg_o[2*k] = negb[k];
  end

  always_comb begin
    logic [W-1:0] row;
    rows_o = '0;
    for (int k = 0; k < NR; k++) begin
      row = '0;
      for (int j = 0; j <= YW; j++)
        if (2*k + j < W) row[2*k+j] = rbits[k][j];
      if (k == 0) begin
        row[YW+1] =  rbits[0][YW];
        row[YW+2] = ~rbits[0][YW];
      end else if (2*k + YW + 1 < W) begin
        row[2*k+YW+1] = 1'b1;
      end
      rows_o[k*W +: W] = row;
    end
  end

endmodule

// File: rtl/booth_pp_gen_chk.sv
module booth_pp_gen_chk #(
  parameter int XW = 8,
  parameter int YW = 12
) (
  input logic [XW-1:0]                 x_i,
  input logic [YW-1:0]                 y_i,
  input logic [((XW+1)/2)*(XW+YW)-1:0] rows_o,
  input logic [XW+YW-1:0]              neg_o
);

  localparam int W  = XW + YW;
  localparam int NR = (XW + 1) / 2;

  logic [W-1:0] acc;
  logic [W-1:0] prod;
  logic         low_clear;
  logic         odd_clear;

  always_comb begin
    prod = W'($signed(x_i)) * W'($signed(y_i));
    acc  = neg_o;
    low_clear = 1'b1;
    for (int k = 0; k < NR; k++) begin
      acc = acc + rows_o[k*W +: W];
      for (int c = 0; c < 2*k; c++)
        if (rows_o[k*W + c]) low_clear = 1'b0;
    end
    odd_clear = 1'b1;
    for (int c = 1; c < W; c += 2)
      if (neg_o[c]) odd_clear = 1'b0;
  end

  always_comb begin
    AST_SUM_EQ_PRODUCT: assert (acc == prod) else $error("weighted sum differs from product"); // R1
    AST_ROW_BELOW_BASE_CLEAR: assert (low_clear) else $error("row bit below its base column"); // R2
    AST_NEG_EVEN_ONLY: assert (odd_clear) else $error("negate bit in odd column"); // R4
    AST_ZERO_X_NO_NEG: assert (x_i != '0 || neg_o == '0) else $error("negate with zero multiplier"); // R4
    AST_ZERO_X_ROW0_CLEAR: assert (x_i != '0 || rows_o[YW-1:0] == '0) else $error("row0 nonzero for zero multiplier"); // R3
  end

endmodule

bind booth_pp_gen booth_pp_gen_chk #(.XW(XW), .YW(YW)) u_booth_pp_gen_chk (
  .x_i    (x_i),
  .y_i    (y_i),
  .rows_o (rows_o),
  .neg_o  (neg_o)
);

// File: tb/booth_pp_gen_bench.sv
module booth_pp_harness #(
  parameter int    XW      = 4,
  parameter int    YW      = 4,
  parameter bit    EXHAUST = 1'b1,
  parameter int    NRAND   = 0,
  parameter string SUMTAG  = "R1"
) (
  input  logic clk,
  input  logic start,
  output logic done,
  output int   checks,
  output int   fails
);

  localparam int W  = XW + YW;
  localparam int NR = (XW + 1) / 2;

  logic [XW-1:0]      x;
  logic [YW-1:0]      y;
  logic [NR*W-1:0]    rows;
  logic [W-1:0]       neg;

  booth_pp_gen #(.XW(XW), .YW(YW)) u_booth_pp_gen (
    .x_i    (x),
    .y_i    (y),
    .rows_o (rows),
    .neg_o  (neg)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s XW=%0d YW=%0d x=%0h y=%0h actual=%0h expected=%0h",
               req, XW, YW, x, y, act, exp);
    end
  endtask

  task automatic evaluate();
    longint wmask = (longint'(1) << W) - 1;
    longint ymask = (longint'(1) << YW) - 1;
    longint rmask = (longint'(1) << (YW + 1)) - 1;
    longint xs = longint'($signed(x));
    longint ys = longint'($signed(y));
    longint xe = (xs << 1);
    longint acc = longint'(neg);
    for (int k = 0; k < NR; k++) begin
      int     m = -2 * int'((xe >> (2*k+2)) & 1) + int'((xe >> (2*k+1)) & 1) + int'((xe >> (2*k)) & 1);
      longint raw;
      longint top;
      longint er;
      longint act = longint'(rows[k*W +: W]);
      if (m == 0) raw = 0;
      else if (m > 0) raw = (longint'(m) * ys) & rmask;
      else raw = ~(longint'(-m) * ys) & rmask;
      top = (raw >> YW) & 1;
      if (k > 0) raw = raw ^ (longint'(1) << YW);
      er = raw << (2*k);
      if (k == 0) begin
        er = er | (top << (YW + 1)) | ((1 - top) << (YW + 2));
      end else begin
        er = er | (longint'(1) << (2*k + YW + 1));
      end
      er = er & wmask;
      // R2: nothing below the row base
      check("R2", act & ((longint'(1) << (2*k)) - 1), 0);
      // R3: multiple bits
      check("R3", (act >> (2*k)) & ymask, (er >> (2*k)) & ymask);
      // R5 for later rows, R6 for the first row, R7 truncation
      check(k == 0 ? "R6" : "R5/R7", act >> (2*k + YW), er >> (2*k + YW));
      // R4: negate bit
      check("R4", longint'(neg[2*k]), longint'(m < 0));
      acc = acc + act;
    end
    check(SUMTAG, acc & wmask, (xs * ys) & wmask);
  endtask

  task automatic run_vec(input logic [XW-1:0] xv, input logic [YW-1:0] yv);
    @(posedge clk);
    x = xv;
    y = yv;
    @(negedge clk);
    evaluate();
  endtask

  initial begin
    done   = 1'b0;
    checks = 0;
    fails  = 0;
    x      = '0;
    y      = '0;
    wait (start);
    // reset state: zero operands give a zero product
    @(negedge clk);
    evaluate();
    if (EXHAUST) begin
      for (int a = 0; a < (1 << XW); a++)
        for (int b = 0; b < (1 << YW); b++)
          run_vec(XW'(a), YW'(b));
    end else begin
      run_vec({1'b1, {(XW-1){1'b0}}}, {1'b1, {(YW-1){1'b0}}});
      run_vec({1'b1, {(XW-1){1'b0}}}, {1'b0, {(YW-1){1'b1}}});
      run_vec({XW{1'b1}}, {YW{1'b1}});
      run_vec({1'b0, {(XW-1){1'b1}}}, {1'b1, {(YW-1){1'b0}}});
      for (int n = 0; n < NRAND; n++)
        run_vec(XW'($urandom), YW'($urandom));
    end
    done = 1'b1;
  end

endmodule

module booth_pp_gen_bench;

  logic clk;
  logic rst_n;
  int   cycles;
  logic d0, d1, d2;
  int   c0, c1, c2;
  int   f0, f1, f2;
  int   wd_fail;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // even widths, exhaustive
  booth_pp_harness #(.XW(4), .YW(4), .EXHAUST(1'b1), .NRAND(0), .SUMTAG("R1")) u_h4x4 (
    .clk(clk), .start(rst_n), .done(d0), .checks(c0), .fails(f0));
  // odd multiplier width: sign copy window (R8), dropped constant (R7)
  booth_pp_harness #(.XW(5), .YW(7), .EXHAUST(1'b1), .NRAND(0), .SUMTAG("R1/R7/R8")) u_h5x7 (
    .clk(clk), .start(rst_n), .done(d1), .checks(c1), .fails(f1));
  // default-size random plus corners
  booth_pp_harness #(.XW(8), .YW(12), .EXHAUST(1'b0), .NRAND(2000), .SUMTAG("R1")) u_h8x12 (
    .clk(clk), .start(rst_n), .done(d2), .checks(c2), .fails(f2));

  initial begin
    rst_n   = 1'b0;
    cycles  = 0;
    wd_fail = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    while (!(d0 && d1 && d2) && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!(d0 && d1 && d2)) begin
      wd_fail = 1;
      $display("FAIL watchdog expired after %0d cycles actual=not-done expected=done", cycles);
    end
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", c0 + c1 + c2 + wd_fail, f0 + f1 + f2 + wd_fail);
    $finish;
  end

endmodule